// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary floating-point operands. Each operand has a sign bit, a biased exponent field and a fraction field with an implied leading one. The unit returns the product in the same format, together with flags that mark overflow and underflow. The field widths are parameters, and the defaults give the 32-bit single-precision layout: 1 sign bit, 8 exponent bits and 23 fraction bits.

A caller presents both operands and raises `start` for one cycle, and the operands are registered on that edge. One cycle later the registered result appears and `done` pulses high for a single cycle. The unit accepts a new `start` on every cycle.

Inside, the unit works in five steps:
1. It forms the sign as the XOR of the operand signs.
2. It adds the biased exponents and removes one bias.
3. It multiplies the two significands exactly.
4. It shifts the product right once if the product is 2 or more.
5. It rounds to nearest even from the guard, round and sticky bits. If rounding carries the significand up to 2, it renormalizes once more.

A zero exponent field means zero, so denormal inputs are flushed to zero. Results beyond the normal exponent range saturate to infinity or flush to zero.

Top module: `fp_mul`

## Requirements
- R1: On a clock edge where `start` is 1, the unit captures `op_a` and `op_b`. Exactly one edge later, `result`, `overflow` and `underflow` take the value for the captured operands and `done` is 1 for that one cycle. Operand changes while `start` is 0 do not affect the pending result.
- R2: The result sign bit (bit W-1) is the XOR of the two operand sign bits. This holds for every result, including zero and infinity.
- R3: For nonzero operands, the result is computed as follows:
  - The biased exponent is ea + eb - (2^(EW-1)-1), plus 1 when the significand product (1.fa)*(1.fb) is 2 or more.
  - The fraction is the normalized product rounded to FW bits.
  - When the discarded part is below half an LSB, the product is truncated. When it is above half an LSB, the product is rounded up.
- R4: When the discarded part is exactly half an LSB (guard 1, round 0, sticky 0), the product rounds up only if the kept LSB is 1. The result therefore has an even LSB.
- R5: When rounding up carries the significand to 2.0, the fraction becomes 0 and the exponent grows by one more.
- R6: An operand with exponent field 0 counts as zero, whatever its fraction. The result is then a zero with the R2 sign, and both flags are 0.
- R7: When the final biased exponent exceeds 2^EW-2, the result is infinity (exponent field all ones, fraction 0) with the R2 sign, and `overflow` is 1.
- R8: When the final biased exponent is below 1, the result is zero with the R2 sign, and `underflow` is 1.
- R9: While `rst_n` is 0 and after reset, `done`, `result`, `overflow` and `underflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture operands and begin a multiply |
| op_a | input | EW+FW+1 | First operand {sign, exponent, fraction} |
| op_b | input | EW+FW+1 | Second operand {sign, exponent, fraction} |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | EW+FW+1 | Product {sign, exponent, fraction} |
| overflow | output | 1 | Result saturated to infinity |
| underflow | output | 1 | Result flushed to zero |

## Verification
The bench builds the unit with EW=4 and FW=3, which gives an 8-bit format with a bias of 7. It multiplies every pair of operands whose exponent field is not all ones, in both signs.

At that size, every rounding case is reached many times over from real operand pairs:
- a product below 2 and a product of 2 or more;
- a tie resolved both ways;
- a rounding carry into the exponent;
- overflow and underflow at both edges of the exponent range;
- zero and denormal operands.

The expected values come from an exact integer remainder comparison, not from guard, round and sticky bits.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Nearest-even decision from the kept LSB and the guard/round/sticky bits.
  function automatic logic rne_up(input logic lsb, input logic g,
                                  input logic r, input logic s);
    return g & (r | s | lsb);
  endfunction

  // Bias for an exponent field of the given width.
  function automatic int exp_bias(input int ew);
    return (1 << (ew - 1)) - 1;
  endfunction

endpackage

// File: rtl/fpm_sigmul.sv
module fpm_sigmul #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W   = EW + FW + 1,
  localparam int EXW = EW + 2
) (
  input  logic [W-1:0]          a_q,
  input  logic [W-1:0]          b_q,
  output logic                  sign,
  output logic                  zero_op,
  output logic [FW:0]           mant,
  output logic                  g_bit,
  output logic                  r_bit,
  output logic                  s_bit,
  output logic signed [EXW-1:0] exp_pre
);
  localparam int BIAS = fpm_pkg::exp_bias(EW);
  localparam int PW   = 2 * FW + 2;

  logic [EW-1:0] ea, eb;
  logic [FW:0]   siga, sigb;
  logic [PW-1:0] prod;
  logic          hi;

  assign ea      = a_q[W-2 -: EW];
  assign eb      = b_q[W-2 -: EW];
  assign sign    = a_q[W-1] ^ b_q[W-1];
  assign zero_op = (ea == '0) || (eb == '0);
  assign siga    = {1'b1, a_q[FW-1:0]};
  assign sigb    = {1'b1, b_q[FW-1:0]};
  assign prod    = PW'(siga) * PW'(sigb);
  assign hi      = prod[PW-1];

  // One-step normalization of a product in [1,4).
  always_comb begin
    if (hi) begin
      mant  = prod[PW-1 -: FW+1];
      g_bit = prod[FW];
      r_bit = prod[FW-1];
      s_bit = |prod[FW-2:0];
    end else begin
      mant  = prod[PW-2 -: FW+1];
      g_bit = prod[FW-1];
      r_bit = prod[FW-2];
      s_bit = |prod[FW-3:0];
    end
  end

  assign exp_pre = $signed({2'b00, ea}) + $signed({2'b00, eb})
                 - $signed(EXW'(BIAS)) + $signed({{(EXW-1){1'b0}}, hi});

  // The normalized significand keeps its leading one (R3).
  always_comb begin
    p_hidden_bit_r3: assert (mant[FW] == 1'b1);
  end

endmodule

// File: rtl/fpm_rounder.sv
module fpm_rounder #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W   = EW + FW + 1,
  localparam int EXW = EW + 2
) (
  input  logic                  sign,
  input  logic                  zero_op,
  input  logic [FW:0]           mant,
  input  logic                  g_bit,
  input  logic                  r_bit,
  input  logic                  s_bit,
  input  logic signed [EXW-1:0] exp_pre,
  output logic [W-1:0]          res,
  output logic                  ovf,
  output logic                  unf
);
  localparam int EMAX = (1 << EW) - 2;

  logic                  up, carry;
  logic [FW+1:0]         sum;
  logic [FW:0]           mant_r;
  logic signed [EXW-1:0] exp_fin;

  assign up      = fpm_pkg::rne_up(mant[0], g_bit, r_bit, s_bit);
  assign sum     = {1'b0, mant} + (FW+2)'(up);
  assign carry   = sum[FW+1];
  assign mant_r  = carry ? sum[FW+1:1] : sum[FW:0];
  assign exp_fin = exp_pre + $signed({{(EXW-1){1'b0}}, carry});

  assign ovf = !zero_op && (exp_fin > $signed(EXW'(EMAX)));
  assign unf = !zero_op && (exp_fin < $signed(EXW'(1)));

  always_comb begin
    if (zero_op || unf)
      res = {sign, {(W-1){1'b0}}};
    else if (ovf)
      res = {sign, {EW{1'b1}}, {FW{1'b0}}};
    else
      res = {sign, exp_fin[EW-1:0], mant_r[FW-1:0]};
  end

  // A rounding carry leaves a zero fraction (R5); the flags exclude each other (R7, R8).
  always_comb begin
    p_carry_frac_zero_r5: assert (!carry || (mant_r[FW-1:0] == '0));
    p_flags_exclusive_r7: assert (!(ovf && unf));
  end

endmodule

// File: rtl/fp_mul.sv
module fp_mul #(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int W   = EW + FW + 1,
  localparam int EXW = EW + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         done,
  output logic [W-1:0] result,
  output logic         overflow,
  output logic         underflow
);
  logic [W-1:0]          a_q, b_q;
  logic                  start_q;
  logic                  sign, zero_op, g_bit, r_bit, s_bit;
  logic [FW:0]           mant;
  logic signed [EXW-1:0] exp_pre;
  logic [W-1:0]          res_c;
  logic                  ovf_c, unf_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= start;
      if (start) begin
        a_q <= op_a;
        b_q <= op_b;
      end
    end
  end

  fpm_sigmul #(.EW(EW), .FW(FW)) u_sigmul (
    .a_q(a_q), .b_q(b_q), .sign(sign), .zero_op(zero_op), .mant(mant),
    .g_bit(g_bit), .r_bit(r_bit), .s_bit(s_bit), .exp_pre(exp_pre)
  );

  fpm_rounder #(.EW(EW), .FW(FW)) u_rounder (
    .sign(sign), .zero_op(zero_op), .mant(mant), .g_bit(g_bit),
    .r_bit(r_bit), .s_bit(s_bit), .exp_pre(exp_pre),
    .res(res_c), .ovf(ovf_c), .unf(unf_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      done <= start_q;
      if (start_q) begin
        result    <= res_c;
        overflow  <= ovf_c;
        underflow <= unf_c;
      end
    end
  end

  p_done_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[W-1] == $past(a_q[W-1] ^ b_q[W-1])));

  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result[W-2:0] == {{EW{1'b1}}, {FW{1'b0}}}));

  p_unf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (result[W-2:0] == '0));

endmodule

// File: tb/fp_mul_tb.sv
module fp_mul_tb;
  localparam int EW = 4;
  localparam int FW = 3;
  localparam int W  = EW + FW + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         done, overflow, underflow;
  logic [W-1:0] result;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  fp_mul #(.EW(EW), .FW(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .done(done), .result(result), .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Reference: exact remainder compare against half an LSB.
  task automatic model(input logic [7:0] a, input logic [7:0] b,
                       output logic [7:0] r, output bit o, output bit u,
                       output string tag);
    int ea, eb, p, e, sh, q, rem, half;
    bit s;
    s  = a[7] ^ b[7];
    ea = int'(a[6:3]);
    eb = int'(b[6:3]);
    o  = 0;
    u  = 0;
    if (ea == 0 || eb == 0) begin
      r = {s, 7'd0};
      tag = "R6";
      return;
    end
    p = (8 + int'(a[2:0])) * (8 + int'(b[2:0]));
    e = ea + eb - 7;
    tag = "R3";
    if (p >= 128) begin
      sh = 4;
      e  = e + 1;
    end else begin
      sh = 3;
    end
    q    = p >> sh;
    rem  = p & ((1 << sh) - 1);
    half = 1 << (sh - 1);
    if (rem == half) tag = "R4";
    if (rem > half || (rem == half && (q % 2) == 1)) q = q + 1;
    if (q == 16) begin
      q = 8;
      e = e + 1;
      tag = "R5";
    end
    if (e > 14) begin
      o = 1;
      r = {s, 4'hF, 3'd0};
      tag = "R7";
    end else if (e < 1) begin
      u = 1;
      r = {s, 7'd0};
      tag = "R8";
    end else begin
      r = {s, 4'(e), 3'(q)};
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] er;
    bit eo, eu;
    string tag;
    repeat (3) @(negedge clk);
    // R9: reset state while reset is held
    chk(done == 0 && result == 0 && !overflow && !underflow, "R9", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && result == 0 && !overflow && !underflow, "R9", int'(result), 0);
    for (int ia = 0; ia < 256; ia++) begin
      if (ia[6:3] == 4'hF) continue;
      for (int ib = 0; ib < 256; ib++) begin
        if (ib[6:3] == 4'hF) continue;
        op_a  = 8'(ia);
        op_b  = 8'(ib);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a  = ~8'(ia);          // must not disturb the pending result (R1)
        op_b  = 8'(ib) ^ 8'h5A;
        chk(done == 1'b0, "R1", int'(done), 0);
        @(negedge clk);
        model(8'(ia), 8'(ib), er, eo, eu, tag);
        chk(done == 1'b1, "R1", int'(done), 1);
        chk(result[7] == er[7], "R2", int'(result[7]), int'(er[7]));
        chk(result == er && overflow == eo && underflow == eu, tag,
            int'({overflow, underflow, result}), int'({eo, eu, er}));
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R1", int'(done), 0);
    summary();
  end

endmodule